// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit holds the interrupt state of a packet-mode I2C controller. Eight single-cycle event inputs each set their own sticky status bit. Software reads the status register and clears any set of bits by writing ones to them. A mask register selects which of the latched events may raise the controller's single interrupt line. The line is driven from a flop, so it follows the masked status one cycle later.

A second register layout exists for an alternate build of the controller, in which register offsets move. When `alt_map_i` is high, each register offset at or above 0x050 moves up by 0x010, and each offset below 0x050 moves up by 0x040. The same translation is also available on a separate lookup port, so that neighbouring blocks can place their own registers. In the alternate layout there is also a one-bit done flag. It sits at bit 30 of offset 0x00C, an address that does not move, and it is set by its own event input.

Top module: `isr_unit`

## Requirements
- R1: While `rst` is high and after its release, the status bits, the mask bits, the done flag and `irq_o` are all 0.
- R2: A high bit of `evt_i` sets the matching status bit at the next clock edge, and the bit stays set until it is cleared. Bit map: 7 packet complete, 6 all packets complete, 5 transmit overflow, 4 receive underflow, 3 no acknowledge, 2 arbitration lost, 1 transmit request, 0 receive request.
- R3: A write to the status register clears each status bit whose `wdata_i[7:0]` bit is 1 and leaves the others alone, so writing 0xFF empties it. Reads return the status in bits 7:0 and zeros above.
- R4: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R5: A write to the mask register loads `wdata_i[7:0]`, and a read returns that value in bits 7:0. A mask bit of 1 enables the matching source.
- R6: `irq_o` is a flop that takes the OR of (status AND mask), ORed with the done flag, one cycle after those values hold.
- R7: With `alt_map_i` low, `xlat_out_o` equals `xlat_in_i`. With it high, an offset of 0x050 or above gains 0x010 and an offset below 0x050 gains 0x040.
- R8: The mask register sits at offset 0x064 and the status register at 0x068, both passed through the R7 relocation. In the alternate layout this gives 0x074 and 0x078. Any other address reads 0, and a write to it changes nothing.
- R9: In the alternate layout, `done_evt_i` sets a flag that is read at bit 30 of offset 0x00C, which is never relocated. Writing 1 to bit 30 there clears the flag, but an event in the same cycle wins. In the standard layout the flag stays 0, and 0x00C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_map_i | input | 1 | Selects the alternate register layout |
| evt_i | input | 8 | Event pulses, one per status bit |
| done_evt_i | input | 1 | Done event for the alternate layout |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt line |
| xlat_in_i | input | 12 | Offset to translate |
| xlat_out_o | output | 12 | Offset after relocation |

## Verification
The assertions assume that `alt_map_i` changes only while `rst` is high, and they check this assumption themselves. Because of it, register addresses and the done flag's reachability stay fixed between resets. They also assume that all inputs are known at every clock edge. The stimulus changes the layout only inside its reset task and drives every input from the first cycle. Its random traffic aims writes mostly at the live register addresses of the current layout, and sometimes at the other layout's addresses, at 0x00C and at stray offsets.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int EVT_W  = 8;
    localparam int REG_AW = 12;
    localparam int REG_DW = 32;

    // status / mask bit positions
    typedef enum int unsigned {
        EV_RX_REQ   = 0,
        EV_TX_REQ   = 1,
        EV_ARB_LOST = 2,
        EV_NO_ACK   = 3,
        EV_RX_UNDER = 4,
        EV_TX_OVER  = 5,
        EV_ALL_DONE = 6,
        EV_PKT_DONE = 7
    } evt_bit_e;

    // logical register offsets (before relocation)
    localparam int unsigned LOG_MASK_OFF = 'h064;
    localparam int unsigned LOG_STAT_OFF = 'h068;
    // done flag offset of the alternate layout, never relocated
    localparam int unsigned DONE_OFF     = 'h00C;
    localparam int          DONE_POS     = 30;

    // relocation rule of the alternate layout
    localparam int unsigned SPLIT_OFF    = 'h050;
    localparam int unsigned MOVE_HI      = 'h010;
    localparam int unsigned MOVE_LO      = 'h040;

    typedef struct packed {
        logic mask;
        logic stat;
        logic done;
    } reg_hit_t;

endpackage

// File: rtl/isr_sticky_bank.sv
module isr_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        // a set in the same cycle as a clear wins
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (clr_i[i])
                q <= 1'b0;
        end
        assign q_o[i] = q;
    end

endmodule

// File: rtl/isr_addr_map.sv
module isr_addr_map
    import isr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          alt_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] xlat_in_i,
    output reg_hit_t      hit_o,
    output logic [AW-1:0] xlat_out_o
);

    localparam logic [AW-1:0] SPLIT  = AW'(SPLIT_OFF);
    localparam logic [AW-1:0] UP_HI  = AW'(MOVE_HI);
    localparam logic [AW-1:0] UP_LO  = AW'(MOVE_LO);
    localparam logic [AW-1:0] L_MASK = AW'(LOG_MASK_OFF);
    localparam logic [AW-1:0] L_STAT = AW'(LOG_STAT_OFF);
    localparam logic [AW-1:0] L_DONE = AW'(DONE_OFF);

    function automatic logic [AW-1:0] move(input logic [AW-1:0] off, input logic alt);
        if (!alt)
            return off;
        return (off >= SPLIT) ? off + UP_HI : off + UP_LO;
    endfunction

    logic [AW-1:0] mask_at;
    logic [AW-1:0] stat_at;

    always_comb begin
        mask_at    = move(L_MASK, alt_i);
        stat_at    = move(L_STAT, alt_i);
        hit_o.mask = (addr_i == mask_at);
        hit_o.stat = (addr_i == stat_at);
        hit_o.done = alt_i && (addr_i == L_DONE);
        xlat_out_o = move(xlat_in_i, alt_i);
    end

endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    input  logic         side_i,
    output logic         irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= (|(status_i & mask_i)) | side_i;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW,
    parameter int EW = EVT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alt_map_i,
    input  logic [EW-1:0] evt_i,
    input  logic          done_evt_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o,
    input  logic [AW-1:0] xlat_in_i,
    output logic [AW-1:0] xlat_out_o
);

    reg_hit_t      hit;
    logic [EW-1:0] status_q;
    logic [EW-1:0] mask_q;
    logic          done_q;
    logic [EW-1:0] stat_clr;
    logic          done_set;
    logic          done_clr;

    isr_addr_map #(.AW(AW)) u_map (
        .alt_i      (alt_map_i),
        .addr_i     (addr_i),
        .xlat_in_i  (xlat_in_i),
        .hit_o      (hit),
        .xlat_out_o (xlat_out_o)
    );

    assign stat_clr = (wr_en_i && hit.stat) ? wdata_i[EW-1:0] : '0;

    isr_sticky_bank #(.W(EW)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i),
        .clr_i (stat_clr),
        .q_o   (status_q)
    );

    assign done_set = done_evt_i && alt_map_i;
    assign done_clr = wr_en_i && hit.done && wdata_i[DONE_POS];

    isr_sticky_bank #(.W(1)) u_done (
        .clk   (clk),
        .rst   (rst),
        .set_i (done_set),
        .clr_i (done_clr),
        .q_o   (done_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_en_i && hit.mask)
            mask_q <= wdata_i[EW-1:0];
    end

    isr_irq_gen #(.W(EW)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_q),
        .mask_i   (mask_q),
        .side_i   (done_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (hit.mask)
            rdata_o[EW-1:0] = mask_q;
        else if (hit.stat)
            rdata_o[EW-1:0] = status_q;
        else if (hit.done)
            rdata_o[DONE_POS] = done_q;
    end

endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk #(
    parameter int AW = 12,
    parameter int EW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          alt,
    input logic [EW-1:0] evt,
    input logic          done_evt,
    input logic          wr,
    input logic [AW-1:0] addr,
    input logic [EW-1:0] wlow,
    input logic          wdone,
    input logic [AW-1:0] xin,
    input logic [AW-1:0] xout,
    input logic [EW-1:0] status,
    input logic [EW-1:0] mask,
    input logic          done,
    input logic          irq
);

    logic [AW-1:0] stat_at;
    logic [AW-1:0] mask_at;
    logic [EW-1:0] clr;

    assign stat_at = alt ? AW'('h078) : AW'('h068);
    assign mask_at = alt ? AW'('h074) : AW'('h064);
    assign clr     = (wr && addr == stat_at) ? wlow : '0;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq);

    a_r2_event_sticks: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    a_r3_untouched_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

    a_r3_cleared_drop: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(clr) & ~$past(evt)) == '0));

    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        ((evt & clr) != '0) |=> ((status & $past(evt & clr)) == $past(evt & clr)));

    a_r5_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == mask_at) |=> $stable(mask));

    a_r5_mask_loads: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == mask_at) |=> (mask == $past(wlow)));

    a_r6_irq_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past((|(status & mask)) | done)));

    a_r7_identity: assert property (@(posedge clk) disable iff (rst)
        !alt |-> (xout == xin));

    a_r7_upper_move: assert property (@(posedge clk) disable iff (rst)
        (alt && xin >= AW'('h050)) |-> (xout == xin + AW'('h010)));

    a_r7_lower_move: assert property (@(posedge clk) disable iff (rst)
        (alt && xin < AW'('h050)) |-> (xout == xin + AW'('h040)));

    a_r8_layout_held: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(alt));

    a_r9_done_only_alt: assert property (@(posedge clk) disable iff (rst)
        !alt |-> !done);

    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
        (alt && done_evt) |=> done);

    a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
        (alt && wr && addr == AW'('h00C) && wdone && !done_evt) |=> !done);

endmodule

bind isr_unit isr_unit_chk #(.AW(AW), .EW(EW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .alt      (alt_map_i),
    .evt      (evt_i),
    .done_evt (done_evt_i),
    .wr       (wr_en_i),
    .addr     (addr_i),
    .wlow     (wdata_i[EW-1:0]),
    .wdone    (wdata_i[30]),
    .xin      (xlat_in_i),
    .xout     (xlat_out_o),
    .status   (status_q),
    .mask     (mask_q),
    .done     (done_q),
    .irq      (irq_o)
);

// File: tb/tb_isr_unit.sv
`timescale 1ns/1ps
module tb_isr_unit;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alt = 1'b0;
    logic [EW-1:0] evt = '0;
    logic          dne = 1'b0;
    logic          wr  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] xin  = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    logic [AW-1:0] xout;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int seed_sink;

    logic [EW-1:0] m_st = '0;
    logic [EW-1:0] m_mk = '0;
    logic          m_done = 1'b0;
    logic          m_irq = 1'b0;

    always #4 clk = ~clk;

    isr_unit dut (
        .clk        (clk),
        .rst        (rst),
        .alt_map_i  (alt),
        .evt_i      (evt),
        .done_evt_i (dne),
        .wr_en_i    (wr),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq),
        .xlat_in_i  (xin),
        .xlat_out_o (xout)
    );

    function automatic logic [AW-1:0] exp_move(input logic [AW-1:0] a, input logic md);
        if (!md) return a;
        if (a >= 12'h050) return a + 12'h010;
        return a + 12'h040;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        if (a == exp_move(12'h064, alt)) r[7:0] = m_mk;
        else if (a == exp_move(12'h068, alt)) r[7:0] = m_st;
        else if (alt && a == 12'h00C) r[30] = m_done;
        return r;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive, check outputs from earlier cycles, advance the model
    task automatic step(input logic [EW-1:0] e, input logic d, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [AW-1:0] x, input string tag);
        logic [EW-1:0] clr;
        logic          nirq;
        @(negedge clk);
        evt = e; dne = d; wr = w; addr = a; wdata = wd; xin = x;
        #1;
        check({tag, " read"}, rdata, exp_read(a));
        check("R6 irq", DW'(irq), DW'(m_irq));
        check("R7 relocate", DW'(xout), DW'(exp_move(x, alt)));
        @(posedge clk);
        nirq = (|(m_st & m_mk)) | m_done;
        clr  = (w && a == exp_move(12'h068, alt)) ? wd[7:0] : '0;
        m_st = e | (m_st & ~clr);
        if (w && a == exp_move(12'h064, alt)) m_mk = wd[7:0];
        if (alt && d) m_done = 1'b1;
        else if (alt && w && a == 12'h00C && wd[30]) m_done = 1'b0;
        m_irq = nirq;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step('0, 1'b0, 1'b0, a, '0, a, tag);
    endtask

    task automatic wrr(input logic [AW-1:0] a, input logic [DW-1:0] wd);
        step('0, 1'b0, 1'b1, a, wd, a, "seq");
    endtask

    task automatic do_reset(input logic md);
        @(negedge clk);
        rst = 1'b1; alt = md; evt = '0; dne = 1'b0; wr = 1'b0;
        repeat (2) @(posedge clk);
        m_st = '0; m_mk = '0; m_done = 1'b0; m_irq = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic random_run(input int n);
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        for (int i = 0; i < n; i++) begin
            case ($urandom % 6)
                0: a = exp_move(12'h064, alt);
                1, 2: a = exp_move(12'h068, alt);
                3: a = 12'h00C;
                4: a = exp_move(12'h068, !alt);
                default: a = AW'($urandom);
            endcase
            wd = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
            step(($urandom % 3 == 0) ? EW'($urandom) : '0,
                 ($urandom % 8 == 0), ($urandom % 3 == 0),
                 a, wd, AW'($urandom), "RND");
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_sink = $urandom(32'd5150);

        // standard layout
        do_reset(1'b0);
        rd(12'h068, "R1 status after reset");
        rd(12'h064, "R1 mask after reset");
        step(8'h08, 1'b0, 1'b0, 12'h068, '0, 12'h04F, "seq");
        rd(12'h068, "R2 event latched");
        step(8'h81, 1'b0, 1'b0, 12'h068, '0, 12'h050, "seq");
        rd(12'h068, "R2 sticky");
        wrr(12'h064, 32'h0000_0001);
        rd(12'h064, "R5 mask readback");
        rd(12'h068, "R6 irq rises");
        wrr(12'h068, 32'h0000_0008);
        rd(12'h068, "R3 partial clear");
        step(8'h80, 1'b0, 1'b1, 12'h068, 32'h0000_0080, 12'h000, "seq");
        rd(12'h068, "R4 set wins");
        wrr(12'h068, 32'h0000_00FF);
        rd(12'h068, "R3 full clear");
        rd(12'h068, "R6 irq falls");
        wrr(12'h070, 32'h0000_00FF);
        rd(12'h064, "R8 stray write");
        rd(12'h070, "R8 unmapped read");
        step('0, 1'b1, 1'b1, 12'h00C, 32'h4000_0000, 12'h00C, "seq");
        rd(12'h00C, "R9 ignored in standard");
        random_run(400);

        // alternate layout
        do_reset(1'b1);
        rd(12'h074, "R1 mask after reset alt");
        rd(12'h078, "R1 status after reset alt");
        wrr(12'h074, 32'h0000_00FF);
        rd(12'h064, "R8 old mask offset dead");
        rd(12'h074, "R8 relocated mask");
        step(8'h04, 1'b0, 1'b0, 12'h078, '0, 12'h04F, "seq");
        rd(12'h078, "R8 relocated status");
        step('0, 1'b0, 1'b1, 12'h068, 32'h0000_00FF, 12'h050, "seq");
        rd(12'h078, "R8 old status offset dead");
        wrr(12'h078, 32'h0000_00FF);
        wrr(12'h074, 32'h0000_0000);
        step('0, 1'b1, 1'b0, 12'h00C, '0, 12'h000, "seq");
        rd(12'h00C, "R9 done set");
        rd(12'h04C, "R9 not relocated");
        wrr(12'h00C, 32'h0000_0000);
        rd(12'h00C, "R9 zero write keeps");
        step('0, 1'b1, 1'b1, 12'h00C, 32'h4000_0000, 12'hFF0, "seq");
        rd(12'h00C, "R9 set beats clear");
        wrr(12'h00C, 32'h4000_0000);
        rd(12'h00C, "R9 done cleared");
        random_run(400);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule